// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog timer that software drives through a small register port. It counts down whole seconds, one step per pulse on a once-per-second tick input. The timeout is always a power of two, from 1 to 128 seconds. If software does not restart the count in time, the block raises an interrupt, a reset request, or both. A selector register decides which of these outputs fire.

Software picks the timeout with a 4-bit code equal to log2(seconds) + 3. It starts the timer, then keeps it alive by writing a restart strobe. After each restart it polls a status flag, which confirms that the fresh count has been loaded. Clearing the enable bit stops the countdown, drops the status flag and releases both expiry outputs.

Top module: `guard_timer`

## Requirements
- R1: After reset, the period register reads 9 (64 seconds), the action register reads 0 and the control register reads 0. Both `irq_o` and `rst_req_o` are low. Enabling the timer without writing a period gives expiry on exactly the 64th tick.
- R2: The period code sits in bits [3:0] at address 0x3004, the action select in bits [1:0] at 0x3008, and the control word at 0x300C. A read returns its data on `rdata_o` in the cycle after `rd_en_i`. Any other address reads as 0.
- R3: Control bit 0 is the enable bit and reads back as written. Control bit 1 is a restart strobe and always reads as 0.
- R4: A period code c is first clamped to the range 3..10. Expiry then occurs on exactly the 2^(c-3)-th tick after a load. So codes 0..3 give 1 tick, and codes 10..15 give 128 ticks.
- R5: A load happens on a control write with bit 0 set, when either the timer was disabled or bit 1 is also set. The load takes the period code in force at that moment. A period write while the timer runs does not change the current count.
- R6: Control bit 8 is the status flag. It reads 0 while the timer is disabled, and reads 1 within four register reads after a load.
- R7: While the timer is disabled, ticks do not advance the count. Re-enabling the timer reloads the full period.
- R8: At expiry, `irq_o` rises. `rst_req_o` also rises unless the action select equals 2; the values 0, 1 and 3 all request a reset. Both outputs stay high until the next load or until the timer is disabled.
- R9: A restart written before expiry reloads the full period, so no expiry occurs at the old deadline.
- R10: Ticks that arrive after expiry leave both outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 16 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Expiry interrupt |
| rst_req_o | output | 1 | Expiry reset request |

## Verification
A count that is off by one shows up at the expiry outputs a single tick early or late. The bench therefore checks, for each period code including clamped ones, that the outputs are low after one tick fewer than the period and high after the full period. If the latched period or the load condition is wrong, a restart or a mid-run period write moves the deadline by at least one tick, and that is visible within a few seconds of ticks. A status flag stuck in either state appears on the next read of the control register, and a wrong action decode appears on `rst_req_o` two cycles after expiry.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_KICK_BIT = 1;
  localparam int CTRL_STAT_BIT = 8;

  typedef enum logic [1:0] {
    ACT_BOTH     = 2'd0,
    ACT_BOTH_A   = 2'd1,
    ACT_IRQ_ONLY = 2'd2,
    ACT_BOTH_B   = 2'd3
  } act_e;
endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import guard_timer_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int PER_W      = 4,
  parameter int CODE_DEF   = 9,
  parameter logic [ADDR_W-1:0] OFF_PERIOD = 16'h3004,
  parameter logic [ADDR_W-1:0] OFF_ACTION = 16'h3008,
  parameter logic [ADDR_W-1:0] OFF_CTRL   = 16'h300C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              status_i,
  output logic [PER_W-1:0]  period_code_o,
  output logic [1:0]        act_sel_o,
  output logic              run_o,
  output logic              load_req_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_per, hit_act, hit_ctl;
  logic [DATA_W-1:0] rd_mux;
  logic wd_unused;

  assign hit_per = (addr_i == OFF_PERIOD);
  assign hit_act = (addr_i == OFF_ACTION);
  assign hit_ctl = (addr_i == OFF_CTRL);
  assign wd_unused = &{1'b0, wdata_i[DATA_W-1:PER_W]};

  always_comb begin
    rd_mux = '0;
    if (hit_per) rd_mux[PER_W-1:0] = period_code_o;
    if (hit_act) rd_mux[1:0] = act_sel_o;
    if (hit_ctl) begin
      rd_mux[CTRL_RUN_BIT]  = run_o;
      rd_mux[CTRL_STAT_BIT] = status_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_code_o <= PER_W'(CODE_DEF);
      act_sel_o     <= ACT_BOTH;
      run_o         <= 1'b0;
      load_req_o    <= 1'b0;
      rdata_o       <= '0;
    end else begin
      load_req_o <= 1'b0;
      if (wr_en_i) begin
        if (hit_per) period_code_o <= wdata_i[PER_W-1:0];
        if (hit_act) act_sel_o <= wdata_i[1:0];
        if (hit_ctl) begin
          run_o      <= wdata_i[CTRL_RUN_BIT];
          load_req_o <= wdata_i[CTRL_RUN_BIT] &
                        (wdata_i[CTRL_KICK_BIT] | ~run_o);
        end
      end
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  a_r3_kick_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && hit_ctl) |=> !rdata_o[CTRL_KICK_BIT]);
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int PER_W    = 4,
  parameter int CODE_MIN = 3,
  parameter int CODE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_req_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_code_i,
  output logic             expired_o,
  output logic             status_o
);
  localparam int CNT_W = CODE_MAX - CODE_MIN + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic [PER_W-1:0] code_c;
  logic             armed_q;

  always_comb begin
    if (period_code_i < PER_W'(CODE_MIN))      code_c = PER_W'(CODE_MIN);
    else if (period_code_i > PER_W'(CODE_MAX)) code_c = PER_W'(CODE_MAX);
    else                                       code_c = period_code_i;
    load_val = CNT_W'(1) << (code_c - PER_W'(CODE_MIN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
      status_o  <= 1'b0;
      armed_q   <= 1'b0;
    end else if (!run_i) begin
      expired_o <= 1'b0;
      status_o  <= 1'b0;
      armed_q   <= 1'b0;
    end else if (load_req_i) begin
      cnt_q     <= load_val;
      expired_o <= 1'b0;
      status_o  <= 1'b0;
      armed_q   <= 1'b1;
    end else begin
      if (armed_q) begin
        status_o <= 1'b1;
        armed_q  <= 1'b0;
      end
      if (tick_i && !expired_o && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) expired_o <= 1'b1;
      end
    end
  end

  a_r7_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(cnt_q));
  a_r6_status_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !status_o);
  a_r10_expiry_held: assert property (@(posedge clk) disable iff (rst)
    (expired_o && run_i && !load_req_i) |=> expired_o);
  a_r4_expired_at_zero: assert property (@(posedge clk) disable iff (rst)
    expired_o |-> (cnt_q == '0));
endmodule

// File: rtl/gt_expiry.sv
module gt_expiry
  import guard_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expired_i,
  input  logic [1:0] act_sel_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= expired_i;
      rst_req_o <= expired_i && (act_sel_i != ACT_IRQ_ONLY);
    end
  end

  a_r8_irq_only_mode: assert property (@(posedge clk) disable iff (rst)
    (act_sel_i == ACT_IRQ_ONLY) |=> !rst_req_o);
  a_r8_req_with_irq: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> irq_o);
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int PER_W    = 4,
  parameter int CODE_MIN = 3,
  parameter int CODE_MAX = 10,
  parameter int CODE_DEF = 9,
  parameter logic [ADDR_W-1:0] OFF_PERIOD = 16'h3004,
  parameter logic [ADDR_W-1:0] OFF_ACTION = 16'h3008,
  parameter logic [ADDR_W-1:0] OFF_CTRL   = 16'h300C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [PER_W-1:0] period_code;
  logic [1:0]       act_sel;
  logic             run, load_req, status, expired;

  gt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_W(PER_W), .CODE_DEF(CODE_DEF),
    .OFF_PERIOD(OFF_PERIOD), .OFF_ACTION(OFF_ACTION), .OFF_CTRL(OFF_CTRL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status),
    .period_code_o(period_code), .act_sel_o(act_sel), .run_o(run),
    .load_req_o(load_req), .rdata_o(rdata_o)
  );

  gt_counter #(
    .PER_W(PER_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
  ) u_counter (
    .clk(clk), .rst(rst), .run_i(run), .load_req_i(load_req),
    .tick_i(sec_tick_i), .period_code_i(period_code),
    .expired_o(expired), .status_o(status)
  );

  gt_expiry u_expiry (
    .clk(clk), .rst(rst), .expired_i(expired), .act_sel_i(act_sel),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/guard_timer_bench.sv
module guard_timer_bench;
  localparam logic [15:0] A_PER = 16'h3004;
  localparam logic [15:0] A_ACT = 16'h3008;
  localparam logic [15:0] A_CTL = 16'h300C;
  localparam int NVEC = 7;
  // code, action select, ticks to expiry, expected reset request
  localparam int unsigned VEC [NVEC][4] = '{
    '{3, 0, 1, 1}, '{4, 2, 2, 0}, '{6, 1, 8, 1}, '{0, 3, 1, 1},
    '{15, 2, 128, 0}, '{10, 0, 128, 1}, '{5, 2, 4, 0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  guard_timer u_guard_timer (
    .clk(clk), .rst(rst), .sec_tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic poll_status(input string req);
    logic [31:0] v;
    int seen = 0;
    for (int i = 0; i < 4; i++) begin
      rd(A_CTL, v);
      if (v[8]) seen = 1;
    end
    chk(req, seen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_PER, d); chk("R1 period reset", int'(d), 9);
    rd(A_ACT, d); chk("R1 action reset", int'(d), 0);
    rd(A_CTL, d); chk("R1 ctrl reset / R6 status off", int'(d), 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 rst_req reset", int'(rst_req), 0);
    // R1 default period 64
    wr(A_CTL, 32'h1);
    poll_status("R6 status after enable");
    ticks(63); chk("R1 default not yet", int'(irq), 0);
    ticks(1);  chk("R1 default expiry", int'(irq), 1);
    chk("R8 reset request both", int'(rst_req), 1);
    ticks(5);  chk("R10 irq held after ticks", int'(irq), 1);
    chk("R10 rst_req held", int'(rst_req), 1);
    wr(A_CTL, 32'h0);
    chk("R8 disable drops irq", int'(irq), 0);
    rd(A_CTL, d); chk("R6 status low when off", int'(d[8]), 0);
    // R2 register map
    wr(A_PER, 32'h5); rd(A_PER, d); chk("R2 period readback", int'(d), 5);
    wr(A_ACT, 32'h2); rd(A_ACT, d); chk("R2 action readback", int'(d), 2);
    rd(16'h3010, d); chk("R2 unmapped reads zero", int'(d), 0);
    // R3 strobe reads zero
    wr(A_CTL, 32'h3); rd(A_CTL, d);
    chk("R3 enable reads back", int'(d[0]), 1);
    chk("R3 strobe reads zero", int'(d[1]), 0);
    wr(A_CTL, 32'h0);
    // table walk: R4 R8
    for (int v = 0; v < NVEC; v++) begin
      wr(A_PER, VEC[v][0]);
      wr(A_ACT, VEC[v][1]);
      wr(A_CTL, 32'h3);
      ticks(int'(VEC[v][2]) - 1);
      chk("R4 no early expiry", int'(irq), 0);
      ticks(1);
      chk("R4 expiry on period", int'(irq), 1);
      chk("R8 action decode", int'(rst_req), int'(VEC[v][3]));
      wr(A_CTL, 32'h0);
      chk("R8 released on disable", int'(irq | rst_req), 0);
    end
    // R5 period latched at load
    wr(A_ACT, 32'h0);
    wr(A_PER, 32'h5); wr(A_CTL, 32'h3);
    wr(A_PER, 32'h3);
    ticks(3); chk("R5 mid-run write ignored", int'(irq), 0);
    ticks(1); chk("R5 old period used", int'(irq), 1);
    wr(A_CTL, 32'h3);
    chk("R8 restart drops irq", int'(irq), 0);
    poll_status("R6 status after restart");
    ticks(1); chk("R5 new period at restart", int'(irq), 1);
    wr(A_CTL, 32'h0);
    // R9 restart before expiry
    wr(A_PER, 32'h5); wr(A_CTL, 32'h3);
    ticks(3); wr(A_CTL, 32'h3);
    ticks(3); chk("R9 restart postpones expiry", int'(irq), 0);
    ticks(1); chk("R9 expiry after full reload", int'(irq), 1);
    wr(A_CTL, 32'h0);
    // R7 disabled timer ignores ticks
    wr(A_CTL, 32'h1);
    ticks(2); wr(A_CTL, 32'h0);
    ticks(10); chk("R7 no expiry while off", int'(irq), 0);
    wr(A_CTL, 32'h1);
    ticks(3); chk("R7 reload on re-enable", int'(irq), 0);
    ticks(1); chk("R7 expiry after reload", int'(irq), 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule